// File: doc/BRIEF.md
# CCD Readout Order Controller

This block decides, one command per clock, the order in which a CCD is read. It tells a downstream waveform sequencer when to move charge down one row (row shift), when to move the serial register by one pixel (pixel shift), when to digitise (sample) and when a shift is a fast dump whose charge is never digitised (skip). The detector is read through two output amplifiers at once, each covering half of every row. Each sample therefore yields two pixels: column `c` on the near output and column `COLS-1-c` on the far output, reported together with the row on a sample-valid strobe.

Four modes are selected on `mode`. Full frame reads every pixel. Box mode reads only the pixels inside up to `NBOX` enabled rectangles and fast-skips the rest. Binned mode sums `bin_rows` rows and `bin_cols` pixels on chip before each sample. Drift mode is paced by an external, asynchronous sync input. Each accepted sync edge releases either a whole frame or the next single line, chosen by `line_sel`. A sync edge that arrives while a drift readout is still running is flagged on `overrun` and otherwise dropped.

The controller has five states: IDLE (waiting), ROW (row shift or row skip), PIX (pixel shift or pixel skip), SAMPLE (sample strobe) and EOL (end of line). The transitions are:
- IDLE goes to ROW on a start pulse in a non-drift mode, or on a filtered sync event in drift mode.
- ROW stays in ROW while skipping rows or while a row bin group is incomplete. It goes to PIX when the group is complete, and to EOL after skipping the last row.
- PIX stays in PIX while skipping pixels or while a column bin group is incomplete. It goes to SAMPLE when the group is complete, and to EOL after skipping the last column.
- SAMPLE goes back to PIX, or to EOL once the line is exhausted.
- EOL goes to IDLE at the end of the frame or after a paced line, and otherwise back to ROW.

Top module: `rdo_readout_ctrl`

## Requirements
- R1: After reset all command outputs, `sample_valid`, `done` and `overrun` are low, and they stay low until a start pulse or a sync event arrives.
- R2: Full frame (`mode`=0): a `start` pulse gives, for each of the ROWS rows, one row shift followed by COLS/2 pairs of pixel shift then sample. Samples come in row-major order, with `px_col_b` = COLS-1-`px_col_a`. Binning and box settings have no effect.
- R3: Box mode (`mode`=1): a row outside every enabled box gives one row shift with `cmd_skip` high and no pixel activity. Inside a hit row, a pixel outside every enabled box covering that row gives a pixel shift with `cmd_skip` high and no sample. Pixels inside are sampled. A box whose `box_en` bit is 0 is ignored. Binning has no effect.
- R4: Binned mode (`mode`=2): rows are shifted in groups of the row factor before the pixels of that line. Pixels are shifted in groups of the column factor before one sample. A group is cut short at the last row or column. The reported coordinates are those of the first row and first column of the group.
- R5: A bin factor of 0 acts as 1, and a factor above MAXBIN (8) acts as MAXBIN.
- R6: `sync_in` passes through a two-flop synchroniser. A level is accepted only after two consecutive equal synchronised samples. A one-cycle pulse is ignored, while a pulse of three or more cycles produces exactly one event.
- R7: Drift mode (`mode`=3) with `line_sel`=0: each sync event reads a complete frame starting at row 0.
- R8: Drift mode with `line_sel`=1: each sync event reads the next single row. After the last row the pointer wraps to row 0.
- R9: A sync event that arrives while a drift readout is active, including the end-of-line cycle, pulses `overrun` for one cycle. It starts nothing and does not move the row pointer.
- R10: A sync event outside drift mode is ignored without `overrun`. A `start` pulse in drift mode, or while a readout is active, is ignored.
- R11: At most one of row shift, pixel shift and sample is high in any cycle, and every sample immediately follows a pixel shift.
- R12: `done` is a one-cycle pulse at the end of the frame, or at the end of each line in paced-line drift mode, and no command follows it in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame in modes 0 to 2 |
| mode | input | 2 | 0 full, 1 box, 2 binned, 3 drift |
| line_sel | input | 1 | Drift pacing: 1 one line per sync, 0 one frame per sync |
| bin_rows | input | 4 | Row bin factor |
| bin_cols | input | 4 | Column bin factor |
| box_en | input | NBOX (8) | Per-box enable |
| box_row_lo | input | NBOX*RW (88) | First row of each box, box i at bits i*RW |
| box_row_hi | input | NBOX*RW (88) | Last row of each box |
| box_col_lo | input | NBOX*CW (80) | First half-row column of each box, box i at bits i*CW |
| box_col_hi | input | NBOX*CW (80) | Last half-row column of each box |
| sync_in | input | 1 | Asynchronous external sync |
| cmd_row_shift | output | 1 | Shift the image area by one row |
| cmd_pix_shift | output | 1 | Shift the serial register by one pixel |
| cmd_skip | output | 1 | Qualifies the current shift as a fast dump |
| cmd_sample | output | 1 | Digitise both outputs |
| sample_valid | output | 1 | Coordinates below are valid |
| px_row | output | RW (11) | Row of the sample |
| px_col_a | output | CW (10) | Column seen by the near output |
| px_col_b | output | XW (11) | Column seen by the far output |
| done | output | 1 | End of frame or paced line |
| overrun | output | 1 | Sync event dropped during a drift readout |

## Verification
Two functions can meet in a single cycle: the end-of-line `done` pulse of a paced line, and the arrival of the next filtered sync event. The bench raises `sync_in` a second time exactly ten cycles after the first rise. Counting the filter latency and the nine command cycles of a four-pixel line, this lands the second event on the EOL cycle. The case passes only if `done` and `overrun` are seen high together, exactly one line of samples is produced, and the following clean sync reads the next row rather than skipping one.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    typedef enum logic [1:0] {
        MODE_FULL  = 2'd0,
        MODE_BOX   = 2'd1,
        MODE_BIN   = 2'd2,
        MODE_DRIFT = 2'd3
    } rdo_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_PIX,
        ST_SAMPLE,
        ST_EOL
    } rdo_state_e;

endpackage

// File: rtl/rdo_sync_filter.sv
module rdo_sync_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic event_o
);
    logic meta_q, sync_q, hold_q, level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q  <= 1'b0;
            sync_q  <= 1'b0;
            hold_q  <= 1'b0;
            level_q <= 1'b0;
            event_o <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            hold_q <= sync_q;
            if (sync_q == hold_q) begin
                level_q <= sync_q;
            end
            event_o <= sync_q & hold_q & ~level_q;
        end
    end

    // R6: an event needs two consecutive high synchronised samples
    a_r6_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> ($past(sync_q) && $past(sync_q, 2)));

    // R6: one event per accepted edge
    a_r6_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o);

endmodule

// File: rtl/rdo_box_match.sv
module rdo_box_match #(
    parameter int NBOX = 8,
    parameter int RW   = 11,
    parameter int CW   = 10
) (
    input  logic [NBOX-1:0]    en,
    input  logic [NBOX*RW-1:0] row_lo,
    input  logic [NBOX*RW-1:0] row_hi,
    input  logic [NBOX*CW-1:0] col_lo,
    input  logic [NBOX*CW-1:0] col_hi,
    input  logic [RW-1:0]      row,
    input  logic [CW-1:0]      col,
    output logic               row_hit,
    output logic               pix_hit
);
    logic [NBOX-1:0] in_rows;
    logic [NBOX-1:0] in_both;

    for (genvar i = 0; i < NBOX; i++) begin : g_box
        assign in_rows[i] = en[i]
                          && (row >= row_lo[i*RW +: RW])
                          && (row <= row_hi[i*RW +: RW]);
        assign in_both[i] = in_rows[i]
                          && (col >= col_lo[i*CW +: CW])
                          && (col <= col_hi[i*CW +: CW]);
    end

    assign row_hit = |in_rows;
    assign pix_hit = |in_both;

endmodule

// File: rtl/rdo_readout_ctrl.sv
module rdo_readout_ctrl
    import rdo_pkg::*;
#(
    parameter int ROWS   = 2048,
    parameter int COLS   = 2048,
    parameter int NBOX   = 8,
    parameter int MAXBIN = 8,
    localparam int HALF  = COLS / 2,
    localparam int RW    = $clog2(ROWS),
    localparam int CW    = $clog2(HALF),
    localparam int XW    = $clog2(COLS),
    localparam int BW    = $clog2(MAXBIN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         mode,
    input  logic               line_sel,
    input  logic [BW-1:0]      bin_rows,
    input  logic [BW-1:0]      bin_cols,
    input  logic [NBOX-1:0]    box_en,
    input  logic [NBOX*RW-1:0] box_row_lo,
    input  logic [NBOX*RW-1:0] box_row_hi,
    input  logic [NBOX*CW-1:0] box_col_lo,
    input  logic [NBOX*CW-1:0] box_col_hi,
    input  logic               sync_in,
    output logic               cmd_row_shift,
    output logic               cmd_pix_shift,
    output logic               cmd_skip,
    output logic               cmd_sample,
    output logic               sample_valid,
    output logic [RW-1:0]      px_row,
    output logic [CW-1:0]      px_col_a,
    output logic [XW-1:0]      px_col_b,
    output logic               done,
    output logic               overrun
);
    localparam int RCNT = $clog2(ROWS + 1);
    localparam int CCNT = $clog2(HALF + 1);
    localparam logic [RCNT-1:0] LAST_ROW = RCNT'(ROWS - 1);
    localparam logic [RCNT-1:0] END_ROW  = RCNT'(ROWS);
    localparam logic [CCNT-1:0] LAST_COL = CCNT'(HALF - 1);
    localparam logic [CCNT-1:0] END_COL  = CCNT'(HALF);

    rdo_state_e         st, st_nx;
    rdo_mode_e          lat_mode, mode_in;
    logic               lat_line;
    logic [BW-1:0]      lat_br, lat_bc, bcnt;
    logic [RCNT-1:0]    row_ptr;
    logic [CCNT-1:0]    col_ptr;
    logic [RW-1:0]      grp_row, match_row;
    logic [CW-1:0]      grp_col;
    logic               sync_ev, row_hit, pix_hit;
    logic               go_start, go_sync, skip_row, skip_pix;
    logic               row_last, col_last, row_grp_end, pix_grp_end;
    logic               frame_end, line_pace;

    function automatic logic [BW-1:0] clip_bin(input logic [BW-1:0] f);
        if (f == '0)
            return BW'(1);
        else if (f > BW'(MAXBIN))
            return BW'(MAXBIN);
        return f;
    endfunction

    rdo_sync_filter u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sync_in),
        .event_o  (sync_ev)
    );

    assign match_row = (st == ST_ROW) ? row_ptr[RW-1:0] : grp_row;

    rdo_box_match #(.NBOX(NBOX), .RW(RW), .CW(CW)) u_match (
        .en      (box_en),
        .row_lo  (box_row_lo),
        .row_hi  (box_row_hi),
        .col_lo  (box_col_lo),
        .col_hi  (box_col_hi),
        .row     (match_row),
        .col     (col_ptr[CW-1:0]),
        .row_hit (row_hit),
        .pix_hit (pix_hit)
    );

    assign mode_in     = rdo_mode_e'(mode);
    assign go_start    = start && (mode_in != MODE_DRIFT);
    assign go_sync     = sync_ev && (mode_in == MODE_DRIFT);
    assign skip_row    = (lat_mode == MODE_BOX) && !row_hit;
    assign skip_pix    = (lat_mode == MODE_BOX) && !pix_hit;
    assign row_last    = (row_ptr == LAST_ROW);
    assign col_last    = (col_ptr == LAST_COL);
    assign row_grp_end = (bcnt == lat_br - BW'(1)) || row_last;
    assign pix_grp_end = (bcnt == lat_bc - BW'(1)) || col_last;
    assign frame_end   = (row_ptr == END_ROW);
    assign line_pace   = (lat_mode == MODE_DRIFT) && lat_line;

    // next-state decision
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (go_start || go_sync) st_nx = ST_ROW;
            ST_ROW: begin
                if (skip_row) begin
                    if (row_last) st_nx = ST_EOL;
                end else if (row_grp_end) begin
                    st_nx = ST_PIX;
                end
            end
            ST_PIX: begin
                if (skip_pix) begin
                    if (col_last) st_nx = ST_EOL;
                end else if (pix_grp_end) begin
                    st_nx = ST_SAMPLE;
                end
            end
            ST_SAMPLE: st_nx = (col_ptr == END_COL) ? ST_EOL : ST_PIX;
            ST_EOL:    st_nx = (frame_end || line_pace) ? ST_IDLE : ST_ROW;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // pointers, bin counter and latched settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_mode <= MODE_FULL;
            lat_line <= 1'b0;
            lat_br   <= BW'(1);
            lat_bc   <= BW'(1);
            bcnt     <= '0;
            row_ptr  <= '0;
            col_ptr  <= '0;
            grp_row  <= '0;
            grp_col  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    bcnt <= '0;
                    if (go_start) begin
                        lat_mode <= mode_in;
                        lat_line <= 1'b0;
                        lat_br   <= (mode_in == MODE_BIN) ? clip_bin(bin_rows) : BW'(1);
                        lat_bc   <= (mode_in == MODE_BIN) ? clip_bin(bin_cols) : BW'(1);
                        row_ptr  <= '0;
                    end else if (go_sync) begin
                        lat_mode <= MODE_DRIFT;
                        lat_line <= line_sel;
                        lat_br   <= BW'(1);
                        lat_bc   <= BW'(1);
                        if (!line_sel) row_ptr <= '0;
                    end
                end
                ST_ROW: begin
                    row_ptr <= row_ptr + RCNT'(1);
                    if (!skip_row) begin
                        if (bcnt == '0) grp_row <= row_ptr[RW-1:0];
                        if (row_grp_end) begin
                            bcnt    <= '0;
                            col_ptr <= '0;
                        end else begin
                            bcnt <= bcnt + BW'(1);
                        end
                    end
                end
                ST_PIX: begin
                    col_ptr <= col_ptr + CCNT'(1);
                    if (!skip_pix) begin
                        if (bcnt == '0) grp_col <= col_ptr[CW-1:0];
                        bcnt <= pix_grp_end ? '0 : bcnt + BW'(1);
                    end
                end
                ST_SAMPLE: ;
                ST_EOL: begin
                    if (frame_end) row_ptr <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_row_shift = 1'b0;
        cmd_pix_shift = 1'b0;
        cmd_skip      = 1'b0;
        cmd_sample    = 1'b0;
        sample_valid  = 1'b0;
        done          = 1'b0;
        overrun       = sync_ev && (st != ST_IDLE) && (lat_mode == MODE_DRIFT);
        px_row        = grp_row;
        px_col_a      = grp_col;
        px_col_b      = XW'(COLS - 1) - XW'(grp_col);
        unique case (st)
            ST_IDLE:   ;
            ST_ROW: begin
                cmd_row_shift = 1'b1;
                cmd_skip      = skip_row;
            end
            ST_PIX: begin
                cmd_pix_shift = 1'b1;
                cmd_skip      = skip_pix;
            end
            ST_SAMPLE: begin
                cmd_sample   = 1'b1;
                sample_valid = 1'b1;
            end
            ST_EOL:    done = frame_end || line_pace;
            default:   ;
        endcase
    end

    // R11: commands are mutually exclusive
    a_r11_one_command: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_row_shift, cmd_pix_shift, cmd_sample}));

    // R11: a sample always follows a pixel shift
    a_r11_sample_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sample |-> $past(cmd_pix_shift));

    // R12: nothing is commanded in the cycle after done
    a_r12_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !(cmd_row_shift || cmd_pix_shift || cmd_sample));

    // R2: sample coordinates lie on the detector
    a_r2_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (px_row <= RW'(ROWS - 1)));

endmodule

// File: tb/rdo_readout_ctrl_tb.sv
`timescale 1ns/1ps
module rdo_readout_ctrl_tb;
    localparam int ROWS = 6;
    localparam int COLS = 8;
    localparam int NBOX = 8;
    localparam int RW = 3;
    localparam int CW = 2;
    localparam int XW = 3;

    typedef struct packed {
        logic [1:0] mode;
        logic [3:0] br, bc;
        logic [7:0] rsh, psh, smp, skp;
        logic [3:0] fr, fc, lr, lc;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t TBL [NVEC] = '{
        '{2'd0, 4'd1,  4'd1,  8'd6, 8'd24, 8'd24, 8'd0,  4'd0, 4'd0, 4'd5, 4'd3},
        '{2'd1, 4'd1,  4'd1,  8'd6, 8'd12, 8'd5,  8'd10, 4'd1, 4'd1, 4'd4, 4'd3},
        '{2'd2, 4'd2,  4'd2,  8'd6, 8'd12, 8'd6,  8'd0,  4'd0, 4'd0, 4'd4, 4'd2},
        '{2'd2, 4'd3,  4'd3,  8'd6, 8'd8,  8'd4,  8'd0,  4'd0, 4'd0, 4'd3, 4'd3},
        '{2'd2, 4'd4,  4'd1,  8'd6, 8'd8,  8'd8,  8'd0,  4'd0, 4'd0, 4'd4, 4'd3},
        '{2'd2, 4'd0,  4'd0,  8'd6, 8'd24, 8'd24, 8'd0,  4'd0, 4'd0, 4'd5, 4'd3},
        '{2'd2, 4'd12, 4'd12, 8'd6, 8'd4,  8'd1,  8'd0,  4'd0, 4'd0, 4'd0, 4'd0},
        '{2'd0, 4'd2,  4'd3,  8'd6, 8'd24, 8'd24, 8'd0,  4'd0, 4'd0, 4'd5, 4'd3},
        '{2'd1, 4'd2,  4'd2,  8'd6, 8'd12, 8'd5,  8'd10, 4'd1, 4'd1, 4'd4, 4'd3}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, line_sel = 1'b0, sync_in = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [3:0] bin_rows = 4'd1, bin_cols = 4'd1;
    logic [NBOX-1:0] box_en = '0;
    logic [NBOX*RW-1:0] box_row_lo = '0, box_row_hi = '0;
    logic [NBOX*CW-1:0] box_col_lo = '0, box_col_hi = '0;
    logic cmd_row_shift, cmd_pix_shift, cmd_skip, cmd_sample, sample_valid, done, overrun;
    logic [RW-1:0] px_row;
    logic [CW-1:0] px_col_a;
    logic [XW-1:0] px_col_b;

    always #4 clk = ~clk;

    rdo_readout_ctrl #(.ROWS(ROWS), .COLS(COLS), .NBOX(NBOX)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .line_sel(line_sel),
        .bin_rows(bin_rows), .bin_cols(bin_cols), .box_en(box_en),
        .box_row_lo(box_row_lo), .box_row_hi(box_row_hi),
        .box_col_lo(box_col_lo), .box_col_hi(box_col_hi), .sync_in(sync_in),
        .cmd_row_shift(cmd_row_shift), .cmd_pix_shift(cmd_pix_shift), .cmd_skip(cmd_skip),
        .cmd_sample(cmd_sample), .sample_valid(sample_valid), .px_row(px_row),
        .px_col_a(px_col_a), .px_col_b(px_col_b), .done(done), .overrun(overrun)
    );

    int n_chk = 0, n_err = 0;
    bit finished = 0;
    int c_rsh, c_psh, c_smp, c_skp, c_done, c_ovr, c_both, c_bad, c_colb;
    int f_row, f_col, l_row, l_col;
    bit have_first, prev_pix;

    task automatic clr();
        c_rsh = 0; c_psh = 0; c_smp = 0; c_skp = 0; c_done = 0; c_ovr = 0;
        c_both = 0; c_bad = 0; c_colb = 0; have_first = 0;
        f_row = -1; f_col = -1; l_row = -1; l_col = -1;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_row_shift) c_rsh++;
            if (cmd_pix_shift) c_psh++;
            if (cmd_skip) c_skp++;
            if (done) c_done++;
            if (overrun) c_ovr++;
            if (done && overrun) c_both++;
            if ((32'(cmd_row_shift) + 32'(cmd_pix_shift) + 32'(cmd_sample)) > 1) c_bad++;
            if (cmd_sample && !prev_pix) c_bad++;
            if (cmd_skip && cmd_sample) c_bad++;
            if (sample_valid) begin
                c_smp++;
                if (32'(px_col_b) != COLS - 1 - 32'(px_col_a)) c_colb++;
                if (!have_first) begin
                    f_row = 32'(px_row); f_col = 32'(px_col_a); have_first = 1;
                end
                l_row = 32'(px_row); l_col = 32'(px_col_a);
            end
            prev_pix = cmd_pix_shift;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic sync_hi(input int n);
        @(negedge clk) sync_in = 1'b1;
        repeat (n) @(negedge clk);
        sync_in = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // box 0 rows 1..2 cols 1..2, box 1 row 4 col 3, box 2 disabled covering all
        box_row_lo[0 +: RW] = 3'd1; box_row_hi[0 +: RW] = 3'd2;
        box_col_lo[0 +: CW] = 2'd1; box_col_hi[0 +: CW] = 2'd2;
        box_row_lo[RW +: RW] = 3'd4; box_row_hi[RW +: RW] = 3'd4;
        box_col_lo[CW +: CW] = 2'd3; box_col_hi[CW +: CW] = 2'd3;
        box_row_lo[2*RW +: RW] = 3'd0; box_row_hi[2*RW +: RW] = 3'd5;
        box_col_lo[2*CW +: CW] = 2'd0; box_col_hi[2*CW +: CW] = 2'd3;
        box_en = 8'b0000_0011;
        clr();
        idle(3);
        rst_n = 1'b1;
        idle(10);
        // R1: quiet after reset
        check("R1 commands after reset", c_rsh + c_psh + c_smp + c_skp, 0);
        check("R1 done/overrun after reset", c_done + c_ovr, 0);

        // vector table: R2 R3 R4 R5 R11 R12
        for (int i = 0; i < NVEC; i++) begin
            mode = TBL[i].mode; bin_rows = TBL[i].br; bin_cols = TBL[i].bc;
            clr();
            pulse_start();
            idle(150);
            check($sformatf("R2/R4 row shifts v%0d", i), c_rsh, int'(TBL[i].rsh));
            check($sformatf("R4/R5 pixel shifts v%0d", i), c_psh, int'(TBL[i].psh));
            check($sformatf("R3/R4 samples v%0d", i), c_smp, int'(TBL[i].smp));
            check($sformatf("R3 skips v%0d", i), c_skp, int'(TBL[i].skp));
            check($sformatf("R2 first coord v%0d", i), f_row * 16 + f_col,
                  int'(TBL[i].fr) * 16 + int'(TBL[i].fc));
            check($sformatf("R4 last coord v%0d", i), l_row * 16 + l_col,
                  int'(TBL[i].lr) * 16 + int'(TBL[i].lc));
            check($sformatf("R2 far column v%0d", i), c_colb, 0);
            check($sformatf("R12 done v%0d", i), c_done, 1);
            check($sformatf("R11 ordering v%0d", i), c_bad, 0);
        end

        // R10: start while busy ignored
        mode = 2'd0; clr();
        pulse_start(); idle(10); pulse_start(); idle(150);
        check("R10 start while busy samples", c_smp, 24);
        check("R10 start while busy done", c_done, 1);

        // R10: sync ignored outside drift mode
        clr(); sync_hi(4); idle(30);
        check("R10 sync in full mode", c_smp + c_rsh + c_ovr, 0);

        // R10: start ignored in drift mode
        mode = 2'd3; line_sel = 1'b0; clr();
        pulse_start(); idle(30);
        check("R10 start in drift mode", c_smp + c_rsh, 0);

        // R7: one sync releases a full frame
        clr(); sync_hi(4); idle(150);
        check("R7 frame samples", c_smp, 24);
        check("R7 frame row shifts", c_rsh, 6);
        check("R7 frame done", c_done, 1);
        check("R7 frame starts at row 0", f_row, 0);

        // R8: one line per sync, wrapping after the last row
        line_sel = 1'b1;
        for (int k = 0; k < 7; k++) begin
            clr(); sync_hi(4); idle(40);
            check($sformatf("R8 line %0d samples", k), c_smp, 4);
            check($sformatf("R8 line %0d row", k), l_row, k % 6);
            check($sformatf("R12 line %0d done", k), c_done, 1);
        end

        // R6: one-cycle glitch ignored, pointer stays at row 1
        clr(); sync_hi(1); idle(30);
        check("R6 glitch ignored", c_smp + c_rsh, 0);
        clr(); sync_hi(4); idle(40);
        check("R6 accepted pulse row", l_row, 1);
        check("R6 accepted pulse samples", c_smp, 4);

        // R9: sync during a line
        clr();
        sync_hi(4); idle(3); sync_hi(4); idle(40);
        check("R9 mid-line overrun", c_ovr, 1);
        check("R9 mid-line samples", c_smp, 4);
        check("R9 mid-line row", l_row, 2);
        clr(); sync_hi(4); idle(40);
        check("R9 pointer not advanced", l_row, 3);

        // R9/R12: sync event landing on the end-of-line cycle
        clr();
        sync_hi(4); idle(5); sync_hi(4); idle(40);
        check("R9 coincident done and overrun", c_both, 1);
        check("R9 coincident samples", c_smp, 4);
        check("R9 coincident row", l_row, 4);
        clr(); sync_hi(4); idle(40);
        check("R9 next row after coincidence", l_row, 5);
        check("R11 drift ordering", c_bad, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule